// File: doc/BRIEF.md
# Busy-Flag Command Scheduler

This block sits between a queue of character-display operations and the engine that drives the display's parallel bus. Each queue entry is a register-select bit and a byte. The block hands each entry to the bus engine as a single write. It then holds back the next entry until the display can take it.

There are two ways to decide that the display is ready, and the `use_poll` input picks one when each entry is accepted. In the timed mode the block decodes the byte it just wrote and counts out a fixed execution time. There are three lengths: a long one for clear and home, a short one for every other instruction, and a data-access one for RAM writes. In the polling mode the block issues status reads until bit 7 of the returned byte is low. It keeps the 7-bit address counter from bits 6..0 of the last status read. A cycle budget caps the polling. If the display is still busy when the budget runs out, the block gives up and raises a flag.

Top module: `disp_busy_sched`

## Requirements
- R1: After reset `bus_start` is 0, `ac_value` is 0, `busy_timeout` is 0, and `in_ready` equals `bus_idle`.
- R2: `in_ready` is high only when the scheduler has no transfer, wait or poll in progress and `bus_idle` is high. While `bus_idle` is low, a valid entry is not taken and no `bus_start` is raised.
- R3: In the cycle after an entry is accepted, `bus_start` is high for one cycle with `bus_rw`=0 and `bus_rs`/`bus_wdata` equal to the accepted bit and byte.
- R4: A byte written with RS=0 is classified by its highest set bit. The values 0x01, 0x02 and 0x03 (top set bit 0 or 1) get the long wait `LONG_CYC`. Any byte with a set bit among bits 7..2 gets the short wait `SHORT_CYC`. The value 0x00 also gets `SHORT_CYC`.
- R5: Any byte written with RS=1 gets the data wait `DATA_CYC`.
- R6: In timed mode `in_ready` rises N+1 cycles after the cycle in which `bus_done` is high for the write, where N is the class wait. No status read is issued.
- R7: In polling mode the cycle after the write's `bus_done` starts a status read with `bus_rs`=0 and `bus_rw`=1. Each `bus_done` whose `bus_rdata[7]` is 1 starts another read in the next cycle. A `bus_rdata[7]` of 0 ends the poll, and `in_ready` returns in the next cycle.
- R8: `ac_value` takes `bus_rdata[6:0]` of every completed status read and does not change otherwise, including during timed-mode commands.
- R9: Polling stops at the first completed status read that still shows bit 7 high once at least `POLL_LIMIT` cycles have elapsed. The count runs from the first cycle of the first status `bus_start` through the `bus_done` cycle, inclusive. `busy_timeout` is then set and `in_ready` returns in the next cycle.
- R10: `busy_timeout` stays set until the next entry is accepted, and is cleared by that acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| use_poll | input | 1 | 1 = poll status, 0 = timed wait; sampled on acceptance |
| in_valid | input | 1 | Entry available |
| in_ready | output | 1 | Entry can be accepted this cycle |
| in_rs | input | 1 | Register select of the entry (1 = data) |
| in_byte | input | 8 | Byte of the entry |
| bus_idle | input | 1 | Bus engine has no transfer in progress |
| bus_start | output | 1 | One-cycle request for a bus transfer |
| bus_rs | output | 1 | Register select for the requested transfer |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_wdata | output | 8 | Byte to write |
| bus_done | input | 1 | One-cycle pulse when a transfer completes |
| bus_rdata | input | 8 | Byte returned by a read, valid with `bus_done` |
| ac_value | output | 7 | Address counter from the last status read |
| busy_timeout | output | 1 | Polling gave up with the display still busy |

## Verification
The bench builds the block with `LONG_CYC`=40, `SHORT_CYC`=8, `DATA_CYC`=12 and `POLL_LIMIT`=60. With these values every wait class, and the polling give-up point, finishes in tens of cycles instead of hundreds of thousands. The three classes also differ by enough that a misclassified byte shows up as a wrong ready cycle. With a bus latency of a few cycles, the 60-cycle budget spans about a dozen status reads. That makes the exact read on which polling stops observable, and lets the bench compare it with its own count of elapsed cycles.

// File: rtl/dsched_pkg.sv
package dsched_pkg;

    localparam int BYTE_W = 8;
    localparam int AC_W   = 7;

    typedef enum logic [1:0] {
        CLS_SHORT = 2'd0,
        CLS_LONG  = 2'd1,
        CLS_DATA  = 2'd2
    } wait_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_WAIT = 2'd2,
        ST_POLL = 2'd3
    } sched_st_e;

    typedef struct packed {
        sched_st_e          st;
        logic               start;
        logic               rs;
        logic               rw;
        logic [BYTE_W-1:0]  wdata;
        logic               poll;
        logic [AC_W-1:0]    ac;
        logic               err;
    } sched_regs_t;

endpackage

// File: rtl/dsched_class_dec.sv
module dsched_class_dec
    import dsched_pkg::*;
(
    input  logic              rs,
    input  logic [BYTE_W-1:0] code,
    output wait_cls_e         cls
);
    logic       any_set;
    logic [2:0] top_bit;

    always_comb begin
        any_set = 1'b0;
        top_bit = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            if (code[i]) begin
                any_set = 1'b1;
                top_bit = 3'(i);
            end
        end
        if (rs)
            cls = CLS_DATA;
        else if (any_set && top_bit < 3'd2)
            cls = CLS_LONG;
        else
            cls = CLS_SHORT;
    end
endmodule

// File: rtl/dsched_countdown.sv
module dsched_countdown #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/dsched_elapsed.sv
module dsched_elapsed #(
    parameter int LIMIT = 64,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    output logic reached
);
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (en && cnt_q < TOP)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // elapsed cycles, counted inclusively, equal cnt_q + 1
    assign reached = (cnt_q >= TOP);
endmodule

// File: rtl/disp_busy_sched.sv
module disp_busy_sched
    import dsched_pkg::*;
#(
    parameter int LONG_CYC   = 306000,
    parameter int SHORT_CYC  = 7800,
    parameter int DATA_CYC   = 8600,
    parameter int POLL_LIMIT = 320000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              use_poll,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_rs,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              bus_idle,
    output logic              bus_start,
    output logic              bus_rs,
    output logic              bus_rw,
    output logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_done,
    input  logic [BYTE_W-1:0] bus_rdata,
    output logic [AC_W-1:0]   ac_value,
    output logic              busy_timeout
);
    localparam int MAX_A  = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int MAX_W  = (MAX_A > DATA_CYC) ? MAX_A : DATA_CYC;
    localparam int WAIT_W = $clog2(MAX_W + 1);

    sched_regs_t       q, d;
    wait_cls_e         cls;
    logic              wait_load;
    logic [WAIT_W-1:0] wait_val;
    logic              wait_zero;
    logic              tmo_clear;
    logic              tmo_reached;
    logic              accept;

    dsched_class_dec u_dec (
        .rs   (q.rs),
        .code (q.wdata),
        .cls  (cls)
    );

    dsched_countdown #(.W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (wait_val),
        .zero     (wait_zero)
    );

    dsched_elapsed #(.LIMIT(POLL_LIMIT)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmo_clear),
        .en      (q.st == ST_POLL),
        .reached (tmo_reached)
    );

    assign in_ready = (q.st == ST_IDLE) && bus_idle;
    assign accept   = in_valid && in_ready;

    always_comb begin
        unique case (cls)
            CLS_LONG: wait_val = WAIT_W'(LONG_CYC - 1);
            CLS_DATA: wait_val = WAIT_W'(DATA_CYC - 1);
            default:  wait_val = WAIT_W'(SHORT_CYC - 1);
        endcase
    end

    always_comb begin
        d         = q;
        d.start   = 1'b0;
        wait_load = 1'b0;
        tmo_clear = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.st    = ST_XFER;
                    d.start = 1'b1;
                    d.rs    = in_rs;
                    d.rw    = 1'b0;
                    d.wdata = in_byte;
                    d.poll  = use_poll;
                    d.err   = 1'b0;
                end
            end
            ST_XFER: begin
                if (bus_done) begin
                    if (q.poll) begin
                        d.st      = ST_POLL;
                        d.start   = 1'b1;
                        d.rs      = 1'b0;
                        d.rw      = 1'b1;
                        tmo_clear = 1'b1;
                    end else begin
                        d.st      = ST_WAIT;
                        wait_load = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (wait_zero)
                    d.st = ST_IDLE;
            end
            ST_POLL: begin
                if (bus_done) begin
                    d.ac = bus_rdata[AC_W-1:0];
                    if (!bus_rdata[BYTE_W-1]) begin
                        d.st = ST_IDLE;
                    end else if (tmo_reached) begin
                        d.st  = ST_IDLE;
                        d.err = 1'b1;
                    end else begin
                        d.start = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, start: 1'b0, rs: 1'b0, rw: 1'b0,
                   wdata: '0, poll: 1'b0, ac: '0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign bus_start    = q.start;
    assign bus_rs       = q.rs;
    assign bus_rw       = q.rw;
    assign bus_wdata    = q.wdata;
    assign ac_value     = q.ac;
    assign busy_timeout = q.err;
endmodule

// File: rtl/dsched_chk.sv
module dsched_chk
    import dsched_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_rs,
    input logic [BYTE_W-1:0] in_byte,
    input logic              bus_start,
    input logic              bus_rs,
    input logic              bus_rw,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic              bus_done,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic [AC_W-1:0]   ac_value,
    input logic              busy_timeout
);
    // R2
    ready_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !bus_start);

    // R3
    issue_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (bus_start && !bus_rw &&
            bus_wdata == $past(in_byte) && bus_rs == $past(in_rs)));

    // R7
    status_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && bus_rw) |-> (!bus_rs && $past(bus_done)));

    // R8
    ac_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ac_value) |-> $past(bus_done));

    // R9
    timeout_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_timeout) |-> ($past(bus_done) && $past(bus_rdata[BYTE_W-1])));

    // R10
    timeout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !busy_timeout);
endmodule

bind disp_busy_sched dsched_chk u_chk (.*);

// File: tb/sim_disp_busy_sched.sv
`timescale 1ns/1ps
module sim_disp_busy_sched;
    localparam int LONG_N  = 40;
    localparam int SHORT_N = 8;
    localparam int DATA_N  = 12;
    localparam int LIMIT   = 60;
    localparam int BUS_LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       use_poll = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       in_rs = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       bus_idle;
    logic       bus_start, bus_rs, bus_rw;
    logic [7:0] bus_wdata;
    logic       bus_done = 1'b0;
    logic [7:0] bus_rdata = 8'h00;
    logic [6:0] ac_value;
    logic       busy_timeout;

    always #2.5 clk = ~clk;

    disp_busy_sched #(
        .LONG_CYC(LONG_N), .SHORT_CYC(SHORT_N),
        .DATA_CYC(DATA_N), .POLL_LIMIT(LIMIT)
    ) u0 (.*);

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit finished = 0;

    // behavioural bus engine and display model
    int   remain = 0;
    bit   hold_busy = 0;
    bit   cur_rw = 0;
    int   n_starts = 0, n_status = 0;
    int   snap_status = 0;
    int   began = 0;
    int   last_done_edge = 0;
    int   busy_reads = 0;
    int   ac_base = 0;
    bit   stopped = 0, exp_err = 0;
    int   exp_reads = 0;
    logic [6:0] exp_ac = 7'd0;
    bit   last_wr_rs = 0;
    logic [7:0] last_wr_data = 8'h00;

    assign bus_idle = (remain == 0) && !hold_busy;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        int   idx;
        logic bsy;
        bus_done <= 1'b0;
        if (remain > 0) begin
            remain <= remain - 1;
            if (remain == 1) begin
                bus_done <= 1'b1;
                last_done_edge <= cyc + 1;
                if (cur_rw) begin
                    idx = n_status - snap_status - 1;
                    bsy = (idx < busy_reads);
                    bus_rdata <= {bsy, 7'(ac_base + idx)};
                    if (!stopped) exp_ac <= 7'(ac_base + idx);
                    if (!stopped && (!bsy || (cyc + 2 - began >= LIMIT))) begin
                        stopped <= 1;
                        exp_err <= bsy;
                        exp_reads <= idx + 1;
                    end
                end else begin
                    bus_rdata <= 8'hA5;
                end
            end
        end
        if (bus_start && rst_n) begin
            remain   <= BUS_LAT;
            cur_rw   <= bus_rw;
            n_starts <= n_starts + 1;
            if (bus_rw) begin
                n_status <= n_status + 1;
                if (n_status == snap_status) began <= cyc;
            end else begin
                last_wr_rs   <= bus_rs;
                last_wr_data <= bus_wdata;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // per-clock comparison against the bench's bus occupancy
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(!(in_ready && remain != 0), "R2 ready while bus busy", in_ready, 0);
            check(!(bus_start && remain != 0), "R3 start during transfer", bus_start, 0);
            check(!(bus_start && bus_rw && bus_rs), "R7 status read rs", bus_rs, 0);
        end
    end

    task automatic report();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            report();
        end
    end

    task automatic send(input bit poll, input bit rs, input logic [7:0] b);
        @(negedge clk);
        use_poll = poll; in_rs = rs; in_byte = b; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_ready(output int rc);
        while (!in_ready) @(negedge clk);
        rc = cyc;
    endtask

    function automatic int wait_for(input bit rs, input logic [7:0] b);
        if (rs) return DATA_N;
        if (b == 8'h01 || b == 8'h02 || b == 8'h03) return LONG_N;
        return SHORT_N;
    endfunction

    task automatic run_timed(input bit rs, input logic [7:0] b, input string tag);
        int s0, st0, rc, n;
        logic [6:0] ac0;
        s0 = n_starts; st0 = n_status; ac0 = ac_value;
        n = wait_for(rs, b);
        send(1'b0, rs, b);
        wait_ready(rc);
        check(rc == last_done_edge + 1 + n, tag, rc - last_done_edge, n + 1);
        check(n_starts - s0 == 1 && n_status == st0, "R6 single write, no status",
              n_starts - s0, 1);
        check(last_wr_rs == rs && last_wr_data == b, "R3 issued rs/byte",
              int'(last_wr_data), int'(b));
        check(ac_value == ac0, "R8 ac kept in timed mode", ac_value, ac0);
    endtask

    task automatic run_poll(input int nbusy, input int base, input string tag);
        int rc;
        busy_reads = nbusy; ac_base = base;
        snap_status = n_status; stopped = 0;
        send(1'b1, 1'b0, 8'h0C);
        wait_ready(rc);
        check(n_status - snap_status == exp_reads, {tag, " status read count"},
              n_status - snap_status, exp_reads);
        check(busy_timeout == exp_err, {tag, " timeout flag"}, busy_timeout, exp_err);
        check(ac_value == exp_ac, "R8 ac from last status read", ac_value, exp_ac);
        check(rc == last_done_edge + 1, {tag, " ready after last read"},
              rc - last_done_edge, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        check(bus_start == 1'b0, "R1 no start after reset", bus_start, 0);
        check(ac_value == 7'd0, "R1 ac after reset", ac_value, 0);
        check(busy_timeout == 1'b0, "R1 flag after reset", busy_timeout, 0);

        // R4 long class
        run_timed(1'b0, 8'h01, "R4 0x01 long");
        run_timed(1'b0, 8'h02, "R4 0x02 long");
        run_timed(1'b0, 8'h03, "R4 0x03 long");
        // R4 short class
        run_timed(1'b0, 8'h38, "R4 0x38 short");
        run_timed(1'b0, 8'h80, "R4 0x80 short");
        run_timed(1'b0, 8'h47, "R4 0x47 short");
        run_timed(1'b0, 8'h04, "R4 0x04 short");
        run_timed(1'b0, 8'h00, "R4 0x00 short");
        // R5 data class
        run_timed(1'b1, 8'h02, "R5 data 0x02");
        run_timed(1'b1, 8'hFF, "R5 data 0xFF");

        // R2: bus engine not idle blocks acceptance
        begin
            int s0;
            s0 = n_starts;
            @(negedge clk);
            hold_busy = 1; in_valid = 1'b1; in_rs = 1'b0; in_byte = 8'h0F;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                check(in_ready == 1'b0, "R2 not ready while bus not idle", in_ready, 0);
            end
            check(n_starts == s0, "R2 no start while bus not idle", n_starts - s0, 0);
            in_valid = 1'b0;
            hold_busy = 0;
            @(negedge clk);
            check(in_ready == 1'b1, "R2 ready when bus idle", in_ready, 1);
        end

        // R7 polling
        run_poll(3, 7'h10, "R7 poll three busy");
        run_poll(0, 7'h4E, "R7 poll ready at once");
        run_poll(1, 7'h22, "R7 poll one busy");

        // R9 give-up
        run_poll(1000, 7'h30, "R9 poll give-up");
        check(busy_timeout == 1'b1, "R10 flag held while idle", busy_timeout, 1);
        repeat (5) @(negedge clk);
        check(busy_timeout == 1'b1, "R10 flag still held", busy_timeout, 1);

        // R10 cleared on next acceptance, R8 kept in timed mode
        send(1'b0, 1'b0, 8'h06);
        check(busy_timeout == 1'b0, "R10 flag cleared on accept", busy_timeout, 0);
        begin
            int rc;
            wait_ready(rc);
            check(rc == last_done_edge + 1 + SHORT_N, "R6 timed after give-up",
                  rc - last_done_edge, SHORT_N + 1);
        end

        // R6: mode is sampled on acceptance; timed command after a poll
        run_timed(1'b0, 8'h01, "R6 long after poll");

        repeat (4) @(negedge clk);
        report();
    end
endmodule